// File: doc/BRIEF.md
# DSP Memory Space Decoder

This block sits between the address generators of a small Harvard-architecture signal processor and its memories. Each cycle it may receive one access. The access is a 16-bit address tagged as either program space or data space. The block decides which resource owns that address: the on-chip ROM, one of the on-chip RAM regions, or the external bus. Program and data space are separate 64K-word spaces, so the same address number can mean different things in each space.

The on-chip memory is 544 RAM words and 4K ROM words. One 256-word RAM block can be swapped at run time between the two spaces. Two single-cycle commands move it: one to program space and one to data space. The other 288 RAM words serve data space only. A boot-mode pin chooses what the bottom 4K of program space is. When the pin is high, that range is the on-chip ROM, so fetch after reset starts in ROM. When the pin is low, the ROM is dropped and that range goes off chip.

Any access that no on-chip resource claims goes to the external bus. The block then pulls exactly one active-low space strobe, the one for the space being accessed. The decode result is registered and appears one cycle after the access is presented.

Top module: `dsp_mem_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, the result is idle: `hit_tgt` = 0, both strobes high and `ext_addr` = 0. Reset places the swappable block in data space, so a data access to 0x0200 is decoded as the swappable block (`hit_tgt` = 4) at offset 0.
- R2: When `rom_boot` = 1, a program access to 0x0000–0x0FFF gives `hit_tgt` = 1 (ROM) with `hit_off` equal to the address. Program address 0x1000 is external.
- R3: When `rom_boot` = 0, the ROM is ignored. A program access to 0x0000–0x0FFF is external: `hit_tgt` = 5, `ext_prog_n` = 0 and `ext_addr` equal to the address.
- R4: Data-only RAM occupies data addresses 0x0060–0x007F (`hit_tgt` = 2, offset = address − 0x0060) and 0x0300–0x03FF (`hit_tgt` = 3, offset = address − 0x0300). The neighbouring addresses 0x005F, 0x0080 and 0x0400, and program accesses to these windows, are not decoded as data-only RAM.
- R5: With the swappable block in data space, data addresses 0x0200–0x02FF give `hit_tgt` = 4 with offset = address − 0x0200. Program addresses 0xFF00–0xFFFF are external.
- R6: With the swappable block in program space, program addresses 0xFF00–0xFFFF give `hit_tgt` = 4 with offset = address − 0xFF00. Data addresses 0x0200–0x02FF are then external (`ext_data_n` = 0).
- R7: A pulse on `swap_to_prog` alone moves the block to program space, and a pulse on `swap_to_data` alone moves it to data space. Pulsing both together, or neither, leaves it where it is. An access presented in the same cycle as a pulse still uses the old placement. Accesses from the next cycle on use the new one.
- R8: For an external result (`hit_tgt` = 5), exactly one strobe is low: `ext_prog_n` for program space, `ext_data_n` for data space. `ext_addr` then carries the address. For any other result both strobes are high and `ext_addr` = 0.
- R9: The result for an access presented in cycle n is valid in cycle n+1. A cycle with `acc_valid` = 0 gives `hit_tgt` = 0 (idle) in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_boot | input | 1 | 1: bottom 4K of program space is on-chip ROM; 0: it is external |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_prog | input | 1 | 1: program space, 0: data space |
| acc_addr | input | 16 | Word address of the access |
| swap_to_prog | input | 1 | Command: move the swappable block into program space |
| swap_to_data | input | 1 | Command: move the swappable block into data space |
| hit_tgt | output | 3 | 0 idle, 1 ROM, 2 small data RAM, 3 large data RAM, 4 swappable block, 5 external |
| hit_off | output | 12 | Word offset inside the on-chip resource (0 otherwise) |
| ext_prog_n | output | 1 | Active-low program-space strobe to the external bus |
| ext_data_n | output | 1 | Active-low data-space strobe to the external bus |
| ext_addr | output | 16 | Address on the external bus for an external access, else 0 |

## Verification
Every decode result, with its target, offset, strobes and external address, is due exactly one clock after its access is driven. The driver issues one item per cycle, idle cycles included, and queues the expected result. The monitor takes one item off the queue shortly after each rising edge, so each comparison falls in the cycle its result is due. A swap command takes effect one cycle later than the access beside it. The bench model therefore updates its own placement bit only after computing that cycle's expected result. This lets the sequences around a command check both the old and the new placement.

// File: rtl/memdec_pkg.sv
package memdec_pkg;
  localparam int ADDR_W = 16;

  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_ROM  = 3'd1,
    TGT_SCR  = 3'd2,
    TGT_DRAM = 3'd3,
    TGT_SWAP = 3'd4,
    TGT_EXT  = 3'd5
  } tgt_e;

  // Data-only RAM regions: base address, size, target code
  localparam int NUM_DREG = 2;
  localparam int DREG_BASE [NUM_DREG] = '{32'h0060, 32'h0300};
  localparam int DREG_SIZE [NUM_DREG] = '{32, 256};

  function automatic tgt_e dreg_tgt(input int idx);
    return (idx == 0) ? TGT_SCR : TGT_DRAM;
  endfunction
endpackage

// File: rtl/memdec_cfg.sv
module memdec_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_prog,
  input  logic set_data,
  output logic in_prog
);
  logic en;
  logic in_prog_d;

  always_comb begin
    en        = set_prog ^ set_data;
    in_prog_d = set_prog;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  in_prog <= 1'b0;
    else if (en) in_prog <= in_prog_d;
  end
endmodule

// File: rtl/memdec_window.sv
module memdec_window #(
  parameter int ADDR_W = 16,
  parameter int BASE   = 0,
  parameter int WORDS  = 256,
  parameter int OFF_W  = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [OFF_W-1:0]  off
);
  localparam logic [ADDR_W:0] BASE_X = (ADDR_W+1)'(BASE);
  localparam logic [ADDR_W:0] SIZE_X = (ADDR_W+1)'(WORDS);

  logic [ADDR_W:0] rel;

  always_comb begin
    rel = {1'b0, addr} - BASE_X;
    hit = ({1'b0, addr} >= BASE_X) && (rel < SIZE_X);
    off = hit ? rel[OFF_W-1:0] : '0;
  end
endmodule

// File: rtl/memdec_core.sv
module memdec_core
  import memdec_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int OFF_W      = 12,
  parameter int ROM_WORDS  = 4096,
  parameter int SWAP_WORDS = 256,
  parameter int SWAP_DBASE = 32'h0200,
  parameter int SWAP_PBASE = 32'hFF00
) (
  input  logic              valid,
  input  logic              prog,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rom_on,
  input  logic              swap_prog,
  output tgt_e              tgt,
  output logic [OFF_W-1:0]  off
);
  logic             rom_hit, swp_p_hit, swp_d_hit;
  logic [OFF_W-1:0] rom_off, swp_p_off, swp_d_off;
  logic             d_hit [NUM_DREG];
  logic [OFF_W-1:0] d_off [NUM_DREG];

  memdec_window #(.ADDR_W(ADDR_W), .BASE(0), .WORDS(ROM_WORDS), .OFF_W(OFF_W))
    u_rom (.addr(addr), .hit(rom_hit), .off(rom_off));

  memdec_window #(.ADDR_W(ADDR_W), .BASE(SWAP_PBASE), .WORDS(SWAP_WORDS), .OFF_W(OFF_W))
    u_swp_p (.addr(addr), .hit(swp_p_hit), .off(swp_p_off));

  memdec_window #(.ADDR_W(ADDR_W), .BASE(SWAP_DBASE), .WORDS(SWAP_WORDS), .OFF_W(OFF_W))
    u_swp_d (.addr(addr), .hit(swp_d_hit), .off(swp_d_off));

  for (genvar g = 0; g < NUM_DREG; g++) begin : g_dreg
    memdec_window #(.ADDR_W(ADDR_W), .BASE(DREG_BASE[g]), .WORDS(DREG_SIZE[g]), .OFF_W(OFF_W))
      u_win (.addr(addr), .hit(d_hit[g]), .off(d_off[g]));
  end

  always_comb begin
    tgt = TGT_NONE;
    off = '0;
    if (valid) begin
      if (prog) begin
        if (rom_on && rom_hit) begin
          tgt = TGT_ROM;
          off = rom_off;
        end else if (swap_prog && swp_p_hit) begin
          tgt = TGT_SWAP;
          off = swp_p_off;
        end else begin
          tgt = TGT_EXT;
        end
      end else begin
        tgt = TGT_EXT;
        if (!swap_prog && swp_d_hit) begin
          tgt = TGT_SWAP;
          off = swp_d_off;
        end
        for (int i = NUM_DREG - 1; i >= 0; i--) begin
          if (d_hit[i]) begin
            tgt = dreg_tgt(i);
            off = d_off[i];
          end
        end
      end
    end
  end
endmodule

// File: rtl/memdec_outreg.sv
module memdec_outreg
  import memdec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tgt_e              tgt_d,
  input  logic [OFF_W-1:0]  off_d,
  input  logic              prog,
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt_q,
  output logic [OFF_W-1:0]  off_q,
  output logic              ps_n_q,
  output logic              ds_n_q,
  output logic [ADDR_W-1:0] ext_q
);
  logic              is_ext;
  logic              ps_n_d, ds_n_d;
  logic [ADDR_W-1:0] ext_d;

  always_comb begin
    is_ext = (tgt_d == TGT_EXT);
    ps_n_d = !(is_ext && prog);
    ds_n_d = !(is_ext && !prog);
    ext_d  = is_ext ? addr : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= TGT_NONE;
      off_q  <= '0;
      ps_n_q <= 1'b1;
      ds_n_q <= 1'b1;
      ext_q  <= '0;
    end else begin
      tgt_q  <= tgt_d;
      off_q  <= off_d;
      ps_n_q <= ps_n_d;
      ds_n_q <= ds_n_d;
      ext_q  <= ext_d;
    end
  end
endmodule

// File: rtl/dsp_mem_decoder.sv
module dsp_mem_decoder
  import memdec_pkg::*;
#(
  parameter int ROM_WORDS  = 4096,
  parameter int SWAP_WORDS = 256,
  parameter int SWAP_DBASE = 32'h0200,
  parameter int SWAP_PBASE = 32'hFF00,
  localparam int OFF_W     = $clog2(ROM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rom_boot,
  input  logic              acc_valid,
  input  logic              acc_prog,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              swap_to_prog,
  input  logic              swap_to_data,
  output logic [2:0]        hit_tgt,
  output logic [OFF_W-1:0]  hit_off,
  output logic              ext_prog_n,
  output logic              ext_data_n,
  output logic [ADDR_W-1:0] ext_addr
);
  logic swap_in_prog;
  tgt_e tgt_d, tgt_q;
  logic [OFF_W-1:0] off_d;

  memdec_cfg u_cfg (
    .clk(clk), .rst_n(rst_n),
    .set_prog(swap_to_prog), .set_data(swap_to_data),
    .in_prog(swap_in_prog)
  );

  memdec_core #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .ROM_WORDS(ROM_WORDS),
    .SWAP_WORDS(SWAP_WORDS), .SWAP_DBASE(SWAP_DBASE), .SWAP_PBASE(SWAP_PBASE)
  ) u_core (
    .valid(acc_valid), .prog(acc_prog), .addr(acc_addr),
    .rom_on(rom_boot), .swap_prog(swap_in_prog),
    .tgt(tgt_d), .off(off_d)
  );

  memdec_outreg #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .tgt_d(tgt_d), .off_d(off_d), .prog(acc_prog), .addr(acc_addr),
    .tgt_q(tgt_q), .off_q(hit_off), .ps_n_q(ext_prog_n), .ds_n_q(ext_data_n),
    .ext_q(ext_addr)
  );

  assign hit_tgt = tgt_q;
endmodule

// File: rtl/memdec_chk.sv
module memdec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rom_boot,
  input logic        acc_valid,
  input logic        acc_prog,
  input logic [15:0] acc_addr,
  input logic        swap_to_prog,
  input logic        swap_to_data,
  input logic        swap_in_prog,
  input logic [2:0]  hit_tgt,
  input logic        ext_prog_n,
  input logic        ext_data_n
);
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_prog_n && !ext_data_n));

  p_ext_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_tgt == 3'd5) |-> (ext_prog_n != ext_data_n));

  p_onchip_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_tgt != 3'd5) |-> (ext_prog_n && ext_data_n));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc_valid) |-> (hit_tgt == 3'd0));

  p_rom_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_tgt == 3'd1) |-> ($past(rom_boot) && $past(acc_prog)));

  p_boot_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(acc_valid) && $past(acc_prog) && !$past(rom_boot)
     && ($past(acc_addr) == 16'h0000)) |-> !ext_prog_n);

  p_swap_space_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_tgt == 3'd4) |-> ($past(acc_prog) == $past(swap_in_prog)));

  p_set_prog_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_to_prog && !swap_to_data) |=> swap_in_prog);

  p_set_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_to_data && !swap_to_prog) |=> !swap_in_prog);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_to_prog == swap_to_data) |=> $stable(swap_in_prog));
endmodule

bind dsp_mem_decoder memdec_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rom_boot(rom_boot), .acc_valid(acc_valid),
  .acc_prog(acc_prog), .acc_addr(acc_addr), .swap_to_prog(swap_to_prog),
  .swap_to_data(swap_to_data), .swap_in_prog(swap_in_prog),
  .hit_tgt(hit_tgt), .ext_prog_n(ext_prog_n), .ext_data_n(ext_data_n)
);

// File: tb/dsp_mem_decoder_tb_top.sv
`timescale 1ns/1ps
module dsp_mem_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rom_boot, acc_valid, acc_prog, swap_to_prog, swap_to_data;
  logic [15:0] acc_addr;
  logic [2:0]  hit_tgt;
  logic [11:0] hit_off;
  logic        ext_prog_n, ext_data_n;
  logic [15:0] ext_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit model_prog = 0;

  typedef struct {
    logic [2:0]  tgt;
    logic [11:0] off;
    logic        ps_n;
    logic        ds_n;
    logic [15:0] ea;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  dsp_mem_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .rom_boot(rom_boot), .acc_valid(acc_valid),
    .acc_prog(acc_prog), .acc_addr(acc_addr), .swap_to_prog(swap_to_prog),
    .swap_to_data(swap_to_data), .hit_tgt(hit_tgt), .hit_off(hit_off),
    .ext_prog_n(ext_prog_n), .ext_data_n(ext_data_n), .ext_addr(ext_addr)
  );

  function automatic exp_t model(input bit v, input bit p, input logic [15:0] a,
                                 input bit boot, input bit sp, input string tag);
    exp_t e;
    e.tgt = 3'd0; e.off = 12'd0; e.ps_n = 1'b1; e.ds_n = 1'b1; e.ea = 16'd0; e.tag = tag;
    if (v) begin
      if (p) begin
        if (boot && a < 16'h1000) begin e.tgt = 3'd1; e.off = a[11:0]; end
        else if (sp && a >= 16'hFF00) begin e.tgt = 3'd4; e.off = 12'(a - 16'hFF00); end
        else begin e.tgt = 3'd5; e.ps_n = 1'b0; e.ea = a; end
      end else begin
        if (a >= 16'h0060 && a <= 16'h007F) begin e.tgt = 3'd2; e.off = 12'(a - 16'h0060); end
        else if (a >= 16'h0300 && a <= 16'h03FF) begin e.tgt = 3'd3; e.off = 12'(a - 16'h0300); end
        else if (!sp && a >= 16'h0200 && a <= 16'h02FF) begin e.tgt = 3'd4; e.off = 12'(a - 16'h0200); end
        else begin e.tgt = 3'd5; e.ds_n = 1'b0; e.ea = a; end
      end
    end
    return e;
  endfunction

  task automatic step(input bit v, input bit p, input logic [15:0] a, input bit boot,
                      input bit sp_cmd, input bit sd_cmd, input string tag);
    @(negedge clk);
    acc_valid = v; acc_prog = p; acc_addr = a; rom_boot = boot;
    swap_to_prog = sp_cmd; swap_to_data = sd_cmd;
    q.push_back(model(v, p, a, boot, model_prog, tag));
    if (sp_cmd && !sd_cmd) model_prog = 1'b1;
    else if (sd_cmd && !sp_cmd) model_prog = 1'b0;
  endtask

  // Monitor: each result is due one clock after its access
  always @(posedge clk) begin
    #2;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (hit_tgt !== e.tgt || hit_off !== e.off || ext_prog_n !== e.ps_n ||
          ext_data_n !== e.ds_n || ext_addr !== e.ea) begin
        errors++;
        $display("FAIL %s: actual tgt=%0d off=%h ps_n=%b ds_n=%b ea=%h expected tgt=%0d off=%h ps_n=%b ds_n=%b ea=%h",
                 e.tag, hit_tgt, hit_off, ext_prog_n, ext_data_n, ext_addr,
                 e.tgt, e.off, e.ps_n, e.ds_n, e.ea);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R9: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rom_boot = 1'b1; acc_valid = 1'b0; acc_prog = 1'b0;
    acc_addr = 16'h0; swap_to_prog = 1'b0; swap_to_data = 1'b0;
    #23;
    checks++;
    if (hit_tgt !== 3'd0 || ext_prog_n !== 1'b1 || ext_data_n !== 1'b1 || ext_addr !== 16'h0) begin
      errors++;
      $display("FAIL R1 reset: actual tgt=%0d ps_n=%b ds_n=%b ea=%h expected tgt=0 ps_n=1 ds_n=1 ea=0000",
               hit_tgt, ext_prog_n, ext_data_n, ext_addr);
    end
    @(negedge clk); rst_n = 1'b1;

    step(0, 0, 16'h0000, 1, 0, 0, "R1 first idle");
    step(1, 0, 16'h0200, 1, 0, 0, "R1 swap block in data after reset");
    // R2 ROM boot
    step(1, 1, 16'h0000, 1, 0, 0, "R2 rom addr 0");
    step(1, 1, 16'h0FFF, 1, 0, 0, "R2 rom top");
    step(1, 1, 16'h1000, 1, 0, 0, "R2 above rom external");
    // R3 ROM ignored
    step(1, 1, 16'h0000, 0, 0, 0, "R3 external boot addr 0");
    step(1, 1, 16'h0ABC, 0, 0, 0, "R3 rom range external");
    // R4 data-only RAM
    step(1, 0, 16'h0060, 0, 0, 0, "R4 small ram base");
    step(1, 0, 16'h007F, 0, 0, 0, "R4 small ram top");
    step(1, 0, 16'h005F, 0, 0, 0, "R4 below small ram");
    step(1, 0, 16'h0080, 0, 0, 0, "R4 above small ram");
    step(1, 0, 16'h0300, 0, 0, 0, "R4 large ram base");
    step(1, 0, 16'h03FF, 0, 0, 0, "R4 large ram top");
    step(1, 0, 16'h0400, 0, 0, 0, "R4 above large ram");
    step(1, 1, 16'h0300, 0, 0, 0, "R4 program access not data ram");
    // R5 swap block in data space
    step(1, 0, 16'h02FF, 1, 0, 0, "R5 swap data top");
    step(1, 0, 16'h01FF, 1, 0, 0, "R5 below swap data window");
    step(1, 1, 16'hFF00, 1, 0, 0, "R5 program window external");
    step(0, 0, 16'h0200, 1, 0, 0, "R9 idle cycle");
    // R7 move to program; access beside the pulse uses old placement
    step(1, 0, 16'h0210, 1, 1, 0, "R7 same-cycle old placement");
    step(1, 0, 16'h0210, 1, 0, 0, "R6 data window external after move");
    step(1, 1, 16'hFFFF, 1, 0, 0, "R6 swap program top");
    step(1, 1, 16'hFF00, 1, 0, 0, "R6 swap program base");
    step(1, 1, 16'hFEFF, 1, 0, 0, "R6 below program window");
    // R7 both pulses: unchanged
    step(0, 0, 16'h0000, 1, 1, 1, "R7 both pulses idle");
    step(1, 1, 16'hFF80, 1, 0, 0, "R7 both pulses keep program");
    // R7 move back to data
    step(1, 1, 16'hFF80, 1, 0, 1, "R7 same-cycle still program");
    step(1, 1, 16'hFF80, 1, 0, 0, "R7 back to data program external");
    step(1, 0, 16'h0280, 1, 0, 0, "R7 back to data swap hit");
    step(0, 0, 16'h0000, 1, 1, 1, "R7 both pulses idle again");
    step(1, 0, 16'h0280, 1, 0, 0, "R7 both pulses keep data");
    step(0, 0, 16'h0000, 1, 0, 0, "R9 final idle");
    @(posedge clk); #4;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule